// File: doc/BRIEF.md
# Bridge Address Translation Window Unit

This block holds the programmable address translation windows of a processor-to-PCI bridge. Four outbound windows map processor addresses onto bus addresses. Three inbound windows map bus addresses onto local memory. Each window has four 32-bit registers:
- a translation address;
- an extended word, stored only;
- a base address;
- an attribute word that carries the enable bit and the size field.

Software reaches these registers through a single-cycle register port. The port decodes byte offsets of a 4 KiB bridge region, and only the upper 1 KiB holds registers.

Each direction has its own lookup channel. A request carries one address and is accepted with a valid/ready handshake. The response comes one cycle later and reports hit or miss, the translated address and the identifier of the window that matched. The response stays stable for as long as the consumer holds its ready low. While a response is stalled the request side is not ready, so back-pressure passes straight through the one-entry response stage.

Top module: `bridge_xlate_windows`

## Requirements
- R1: After reset every register reads zero, every window is disabled, both response valids are low and both request readies are high.
- R2: Outbound window k (k = 1..4) occupies byte offsets 0xC00 + 0x20·k. Inbound window j (j = 0..2) occupies 0xDA0 + 0x20·j, so its index counts up with the register address. Inside an outbound window the fields are: translation at +0x00, extended translation at +0x04, base at +0x08 and attributes at +0x10. Inside an inbound window the fields are: translation at +0x00, base at +0x08, extended base at +0x0C and attributes at +0x10. Every field stores and reads back all 32 bits.
- R3: A read at an undecoded offset returns zero, and a write to one changes nothing, whether readback or lookups. Undecoded offsets are everything below 0xC00 and the unused slots inside and between windows.
- R4: Bit 31 of the attribute word enables a window. A disabled window never hits.
- R5: Window size in bytes is 2^(f+1), where f is attribute bits [5:0]. The value f = 63 is clamped to a size of 2^63.
- R6: Base and translation registers count 4 KiB pages, so the byte address is the register value shifted left by 12. An address hits when base ≤ address < base + size.
- R7: On a hit the translated address is translation + (address − base), taken modulo 2^64.
- R8: When several enabled windows of one direction hit, the lowest index wins. The outbound identifier reports k (1..4) and the inbound identifier reports j (0..2).
- R9: A lookup that hits no window raises the miss flag, clears the hit flag, and drives both the translated address and the identifier to zero.
- R10: The request ready equals NOT response-valid OR response-ready. An accepted request produces a response-valid on the next cycle. A stalled response holds its flags, address and identifier unchanged.
- R11: A register write takes effect for lookups accepted after the clock edge that performs the write. A lookup accepted on that same edge still sees the old setting.
- R12: A 32-bit read/write timer register sits at offset 0xE20 and has no effect on translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 12 | Byte offset into the 4 KiB bridge region |
| reg_wen | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, same cycle |
| ob_req_valid | input | 1 | Outbound lookup request valid |
| ob_req_ready | output | 1 | Outbound lookup request ready |
| ob_req_addr | input | 64 | Processor address to translate |
| ob_rsp_valid | output | 1 | Outbound response valid |
| ob_rsp_ready | input | 1 | Outbound response consumed |
| ob_rsp_hit | output | 1 | Outbound address hit a window |
| ob_rsp_miss | output | 1 | Outbound address hit no window |
| ob_rsp_addr | output | 64 | Translated bus address, zero on miss |
| ob_rsp_win | output | 3 | Winning outbound window 1..4, zero on miss |
| ib_req_valid | input | 1 | Inbound lookup request valid |
| ib_req_ready | output | 1 | Inbound lookup request ready |
| ib_req_addr | input | 64 | Bus address to translate |
| ib_rsp_valid | output | 1 | Inbound response valid |
| ib_rsp_ready | input | 1 | Inbound response consumed |
| ib_rsp_hit | output | 1 | Inbound address hit a window |
| ib_rsp_miss | output | 1 | Inbound address hit no window |
| ib_rsp_addr | output | 64 | Translated local address, zero on miss |
| ib_rsp_win | output | 2 | Winning inbound window 0..2, zero on miss |

## Verification
The assertions assume that reset starts low. They also assume that consumers may hold a response ready low for any number of cycles, and that a requester may change its address or drop valid while it is stalled. The properties therefore cover only what the block itself guarantees: the response holds, ready follows back-pressure, and miss responses are zeroed. The stimulus covers that space. It stalls the outbound response for several cycles while swapping the pending request's address, and it lands a lookup on the same edge as the write that enables its window. Random window settings keep bases within a few hundred pages and size fields between 12 and 19, so random addresses hit, miss, overlap and straddle boundaries often.

// File: rtl/bxw_pkg.sv
package bxw_pkg;
  localparam int REG_W    = 32;
  localparam int SZ_W     = 6;
  localparam int PAGE_SH  = 12;
  localparam int EN_BIT   = 31;

  // field offsets inside one 32-byte window slot
  localparam logic [4:0] SUB_TAR  = 5'h00;
  localparam logic [4:0] SUB_EXT  = 5'h04;
  localparam logic [4:0] SUB_BASE = 5'h08;
  localparam logic [4:0] SUB_EXTB = 5'h0C;
  localparam logic [4:0] SUB_ATTR = 5'h10;

  typedef struct packed {
    logic [REG_W-1:0] tar;
    logic [REG_W-1:0] base;
    logic [REG_W-1:0] attr;
  } win_cfg_t;
endpackage

// File: rtl/bxw_regs.sv
module bxw_regs
  import bxw_pkg::*;
#(
  parameter int          N_OB     = 4,
  parameter int          N_IB     = 3,
  parameter logic [11:0] OB_FIRST = 12'hC20,
  parameter logic [11:0] IB_FIRST = 12'hDA0,
  parameter logic [11:0] TMR_OFF  = 12'hE20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [11:0]            reg_addr,
  input  logic                   reg_wen,
  input  logic [REG_W-1:0]       reg_wdata,
  output logic [REG_W-1:0]       reg_rdata,
  output win_cfg_t [N_OB-1:0]    ob_cfg,
  output win_cfg_t [N_IB-1:0]    ib_cfg
);
  localparam logic [6:0] OB_SLOT0 = OB_FIRST[11:5];
  localparam logic [6:0] IB_SLOT0 = IB_FIRST[11:5];

  logic [6:0] slot;
  logic [4:0] sub;
  assign slot = reg_addr[11:5];
  assign sub  = reg_addr[4:0];

  logic [N_OB-1:0][REG_W-1:0] ob_rd;
  logic [N_IB-1:0][REG_W-1:0] ib_rd;
  logic [REG_W-1:0]           tmr_q;

  // outbound window storage, one slot per window
  for (genvar g = 0; g < N_OB; g++) begin : g_ob
    localparam logic [6:0] MY_SLOT = OB_SLOT0 + 7'(g);
    logic [REG_W-1:0] tar_q, ext_q, base_q, attr_q;
    logic             hit_slot;
    assign hit_slot = (slot == MY_SLOT);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tar_q  <= '0;
        ext_q  <= '0;
        base_q <= '0;
        attr_q <= '0;
      end else if (reg_wen && hit_slot) begin
        case (sub)
          SUB_TAR:  tar_q  <= reg_wdata;
          SUB_EXT:  ext_q  <= reg_wdata;
          SUB_BASE: base_q <= reg_wdata;
          SUB_ATTR: attr_q <= reg_wdata;
          default:  ;
        endcase
      end
    end

    always_comb begin
      ob_rd[g] = '0;
      if (hit_slot) begin
        case (sub)
          SUB_TAR:  ob_rd[g] = tar_q;
          SUB_EXT:  ob_rd[g] = ext_q;
          SUB_BASE: ob_rd[g] = base_q;
          SUB_ATTR: ob_rd[g] = attr_q;
          default:  ob_rd[g] = '0;
        endcase
      end
    end

    assign ob_cfg[g] = '{tar: tar_q, base: base_q, attr: attr_q};
  end

  // inbound window storage; index rises with register address
  for (genvar g = 0; g < N_IB; g++) begin : g_ib
    localparam logic [6:0] MY_SLOT = IB_SLOT0 + 7'(g);
    logic [REG_W-1:0] tar_q, base_q, extb_q, attr_q;
    logic             hit_slot;
    assign hit_slot = (slot == MY_SLOT);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tar_q  <= '0;
        base_q <= '0;
        extb_q <= '0;
        attr_q <= '0;
      end else if (reg_wen && hit_slot) begin
        case (sub)
          SUB_TAR:  tar_q  <= reg_wdata;
          SUB_BASE: base_q <= reg_wdata;
          SUB_EXTB: extb_q <= reg_wdata;
          SUB_ATTR: attr_q <= reg_wdata;
          default:  ;
        endcase
      end
    end

    always_comb begin
      ib_rd[g] = '0;
      if (hit_slot) begin
        case (sub)
          SUB_TAR:  ib_rd[g] = tar_q;
          SUB_BASE: ib_rd[g] = base_q;
          SUB_EXTB: ib_rd[g] = extb_q;
          SUB_ATTR: ib_rd[g] = attr_q;
          default:  ib_rd[g] = '0;
        endcase
      end
    end

    assign ib_cfg[g] = '{tar: tar_q, base: base_q, attr: attr_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              tmr_q <= '0;
    else if (reg_wen && reg_addr == TMR_OFF) tmr_q <= reg_wdata;
  end

  // every source is zero unless selected, so an OR merges them
  always_comb begin
    reg_rdata = (reg_addr == TMR_OFF) ? tmr_q : '0;
    for (int i = 0; i < N_OB; i++) reg_rdata = reg_rdata | ob_rd[i];
    for (int i = 0; i < N_IB; i++) reg_rdata = reg_rdata | ib_rd[i];
  end
endmodule

// File: rtl/bxw_win_match.sv
module bxw_win_match
  import bxw_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  win_cfg_t              cfg,
  input  logic [ADDR_W-1:0]     addr,
  output logic                  hit,
  output logic [ADDR_W-1:0]     xaddr
);
  localparam int               EXP_W   = $clog2(ADDR_W) + 1;
  localparam logic [EXP_W-1:0] EXP_MAX = EXP_W'(ADDR_W - 1);

  logic [ADDR_W-1:0] base_b, tar_b, offset, size;
  logic [EXP_W-1:0]  exp_raw, exp_use;
  logic              enabled;

  assign enabled = cfg.attr[EN_BIT];
  assign base_b  = ADDR_W'(cfg.base) << PAGE_SH;
  assign tar_b   = ADDR_W'(cfg.tar)  << PAGE_SH;

  // size is 2^(field+1), capped so it stays representable
  assign exp_raw = EXP_W'(cfg.attr[SZ_W-1:0]) + EXP_W'(1);
  assign exp_use = (exp_raw > EXP_MAX) ? EXP_MAX : exp_raw;
  assign size    = ADDR_W'(1) << exp_use;

  // compare the offset rather than base+size to avoid a carry out
  assign offset  = addr - base_b;
  assign hit     = enabled && (addr >= base_b) && (offset < size);
  assign xaddr   = tar_b + offset;
endmodule

// File: rtl/bxw_lookup.sv
module bxw_lookup
  import bxw_pkg::*;
#(
  parameter int N       = 4,
  parameter int ADDR_W  = 64,
  parameter int ID_W    = 3,
  parameter int ID_BASE = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  win_cfg_t [N-1:0]      cfg,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ADDR_W-1:0]     req_addr,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic                  rsp_hit,
  output logic                  rsp_miss,
  output logic [ADDR_W-1:0]     rsp_addr,
  output logic [ID_W-1:0]       rsp_win
);
  logic [N-1:0]             hit_vec;
  logic [N-1:0][ADDR_W-1:0] xaddr_vec;

  for (genvar g = 0; g < N; g++) begin : g_win
    bxw_win_match #(.ADDR_W(ADDR_W)) u_match (
      .cfg   (cfg[g]),
      .addr  (req_addr),
      .hit   (hit_vec[g]),
      .xaddr (xaddr_vec[g])
    );
  end

  logic              sel_hit;
  logic [ADDR_W-1:0] sel_addr;
  logic [ID_W-1:0]   sel_id;

  // scan from the top so the lowest index is written last and wins
  always_comb begin
    sel_hit  = 1'b0;
    sel_addr = '0;
    sel_id   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        sel_hit  = 1'b1;
        sel_addr = xaddr_vec[i];
        sel_id   = ID_W'(ID_BASE + i);
      end
    end
  end

  logic accept;
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_addr  <= '0;
      rsp_win   <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= sel_hit;
      rsp_miss  <= !sel_hit;
      rsp_addr  <= sel_addr;
      rsp_win   <= sel_id;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bridge_xlate_windows.sv
module bridge_xlate_windows
  import bxw_pkg::*;
#(
  parameter int  N_OB    = 4,
  parameter int  N_IB    = 3,
  parameter int  ADDR_W  = 64,
  localparam int OB_ID_W = $clog2(N_OB + 1),
  localparam int IB_ID_W = (N_IB > 1) ? $clog2(N_IB) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [11:0]         reg_addr,
  input  logic                reg_wen,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic                ob_req_valid,
  output logic                ob_req_ready,
  input  logic [ADDR_W-1:0]   ob_req_addr,
  output logic                ob_rsp_valid,
  input  logic                ob_rsp_ready,
  output logic                ob_rsp_hit,
  output logic                ob_rsp_miss,
  output logic [ADDR_W-1:0]   ob_rsp_addr,
  output logic [OB_ID_W-1:0]  ob_rsp_win,
  input  logic                ib_req_valid,
  output logic                ib_req_ready,
  input  logic [ADDR_W-1:0]   ib_req_addr,
  output logic                ib_rsp_valid,
  input  logic                ib_rsp_ready,
  output logic                ib_rsp_hit,
  output logic                ib_rsp_miss,
  output logic [ADDR_W-1:0]   ib_rsp_addr,
  output logic [IB_ID_W-1:0]  ib_rsp_win
);
  win_cfg_t [N_OB-1:0] ob_cfg;
  win_cfg_t [N_IB-1:0] ib_cfg;

  bxw_regs #(.N_OB(N_OB), .N_IB(N_IB)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wen   (reg_wen),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ob_cfg    (ob_cfg),
    .ib_cfg    (ib_cfg)
  );

  bxw_lookup #(.N(N_OB), .ADDR_W(ADDR_W), .ID_W(OB_ID_W), .ID_BASE(1)) u_ob (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg       (ob_cfg),
    .req_valid (ob_req_valid),
    .req_ready (ob_req_ready),
    .req_addr  (ob_req_addr),
    .rsp_valid (ob_rsp_valid),
    .rsp_ready (ob_rsp_ready),
    .rsp_hit   (ob_rsp_hit),
    .rsp_miss  (ob_rsp_miss),
    .rsp_addr  (ob_rsp_addr),
    .rsp_win   (ob_rsp_win)
  );

  bxw_lookup #(.N(N_IB), .ADDR_W(ADDR_W), .ID_W(IB_ID_W), .ID_BASE(0)) u_ib (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg       (ib_cfg),
    .req_valid (ib_req_valid),
    .req_ready (ib_req_ready),
    .req_addr  (ib_req_addr),
    .rsp_valid (ib_rsp_valid),
    .rsp_ready (ib_rsp_ready),
    .rsp_hit   (ib_rsp_hit),
    .rsp_miss  (ib_rsp_miss),
    .rsp_addr  (ib_rsp_addr),
    .rsp_win   (ib_rsp_win)
  );
endmodule

// File: rtl/bxw_checker.sv
module bxw_checker #(
  parameter int N_OB    = 4,
  parameter int N_IB    = 3,
  parameter int ADDR_W  = 64,
  parameter int OB_ID_W = 3,
  parameter int IB_ID_W = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [11:0]        reg_addr,
  input logic [31:0]        reg_rdata,
  input logic               ob_req_valid,
  input logic               ob_req_ready,
  input logic               ob_rsp_valid,
  input logic               ob_rsp_ready,
  input logic               ob_rsp_hit,
  input logic               ob_rsp_miss,
  input logic [ADDR_W-1:0]  ob_rsp_addr,
  input logic [OB_ID_W-1:0] ob_rsp_win,
  input logic               ib_req_valid,
  input logic               ib_req_ready,
  input logic               ib_rsp_valid,
  input logic               ib_rsp_ready,
  input logic               ib_rsp_hit,
  input logic               ib_rsp_miss,
  input logic [ADDR_W-1:0]  ib_rsp_addr,
  input logic [IB_ID_W-1:0] ib_rsp_win
);
  AST_OB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ob_rsp_valid && !ob_rsp_ready |=> ob_rsp_valid && $stable(ob_rsp_addr) && $stable(ob_rsp_win) && $stable(ob_rsp_hit)); // R10
  AST_IB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ib_rsp_valid && !ib_rsp_ready |=> ib_rsp_valid && $stable(ib_rsp_addr) && $stable(ib_rsp_win) && $stable(ib_rsp_hit)); // R10
  AST_OB_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    ob_rsp_valid && !ob_rsp_ready |-> !ob_req_ready); // R10
  AST_IB_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    ib_rsp_valid && !ib_rsp_ready |-> !ib_req_ready); // R10
  AST_OB_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ob_req_valid && ob_req_ready |=> ob_rsp_valid); // R10
  AST_IB_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ib_req_valid && ib_req_ready |=> ib_rsp_valid); // R10
  AST_OB_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ob_rsp_valid && ob_rsp_miss |-> !ob_rsp_hit && ob_rsp_addr == '0 && ob_rsp_win == '0); // R9
  AST_IB_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ib_rsp_valid && ib_rsp_miss |-> !ib_rsp_hit && ib_rsp_addr == '0 && ib_rsp_win == '0); // R9
  AST_OB_WIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ob_rsp_valid && ob_rsp_hit |-> ob_rsp_win >= OB_ID_W'(1) && ob_rsp_win <= OB_ID_W'(N_OB)); // R8
  AST_IB_WIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ib_rsp_valid && ib_rsp_hit |-> ib_rsp_win < IB_ID_W'(N_IB)); // R8
  AST_LOW_REGION_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr < 12'hC00 |-> reg_rdata == 32'h0); // R3
endmodule

bind bridge_xlate_windows bxw_checker #(
  .N_OB(N_OB), .N_IB(N_IB), .ADDR_W(ADDR_W), .OB_ID_W(OB_ID_W), .IB_ID_W(IB_ID_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .ob_req_valid(ob_req_valid), .ob_req_ready(ob_req_ready),
  .ob_rsp_valid(ob_rsp_valid), .ob_rsp_ready(ob_rsp_ready),
  .ob_rsp_hit(ob_rsp_hit), .ob_rsp_miss(ob_rsp_miss),
  .ob_rsp_addr(ob_rsp_addr), .ob_rsp_win(ob_rsp_win),
  .ib_req_valid(ib_req_valid), .ib_req_ready(ib_req_ready),
  .ib_rsp_valid(ib_rsp_valid), .ib_rsp_ready(ib_rsp_ready),
  .ib_rsp_hit(ib_rsp_hit), .ib_rsp_miss(ib_rsp_miss),
  .ib_rsp_addr(ib_rsp_addr), .ib_rsp_win(ib_rsp_win)
);

// File: tb/bridge_xlate_windows_tb.sv
module bridge_xlate_windows_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [11:0] reg_addr = '0;
  logic        reg_wen = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ob_req_valid = 1'b0, ob_rsp_ready = 1'b1;
  logic        ob_req_ready, ob_rsp_valid, ob_rsp_hit, ob_rsp_miss;
  logic [63:0] ob_req_addr = '0, ob_rsp_addr;
  logic [2:0]  ob_rsp_win;
  logic        ib_req_valid = 1'b0, ib_rsp_ready = 1'b1;
  logic        ib_req_ready, ib_rsp_valid, ib_rsp_hit, ib_rsp_miss;
  logic [63:0] ib_req_addr = '0, ib_rsp_addr;
  logic [1:0]  ib_rsp_win;

  bridge_xlate_windows u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ob_req_valid(ob_req_valid), .ob_req_ready(ob_req_ready), .ob_req_addr(ob_req_addr),
    .ob_rsp_valid(ob_rsp_valid), .ob_rsp_ready(ob_rsp_ready), .ob_rsp_hit(ob_rsp_hit),
    .ob_rsp_miss(ob_rsp_miss), .ob_rsp_addr(ob_rsp_addr), .ob_rsp_win(ob_rsp_win),
    .ib_req_valid(ib_req_valid), .ib_req_ready(ib_req_ready), .ib_req_addr(ib_req_addr),
    .ib_rsp_valid(ib_rsp_valid), .ib_rsp_ready(ib_rsp_ready), .ib_rsp_hit(ib_rsp_hit),
    .ib_rsp_miss(ib_rsp_miss), .ib_rsp_addr(ib_rsp_addr), .ib_rsp_win(ib_rsp_win)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // shadow of the register file, indexed by window identifier
  logic [31:0] s_ob_tar[1:4], s_ob_ext[1:4], s_ob_base[1:4], s_ob_attr[1:4];
  logic [31:0] s_ib_tar[0:2], s_ib_base[0:2], s_ib_extb[0:2], s_ib_attr[0:2];
  logic [31:0] s_tmr;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit win_hits(input logic [31:0] tar, input logic [31:0] base,
                                  input logic [31:0] attr, input logic [63:0] a,
                                  output logic [63:0] x);
    int e;
    logic [63:0] b, size, off;
    e = int'(attr[5:0]) + 1;
    if (e > 63) e = 63;
    size = 64'd1 << e;
    b = {32'h0, base} << 12;
    off = a - b;
    x = ({32'h0, tar} << 12) + off;
    return attr[31] && (a >= b) && (off < size);
  endfunction

  function automatic logic [31:0] model_read(input logic [11:0] a);
    logic [4:0] s;
    s = a[4:0];
    if (a == 12'hE20) return s_tmr;
    for (int k = 1; k <= 4; k++)
      if (a[11:5] == 7'((12'hC00 + 12'(32 * k)) >> 5)) begin
        case (s)
          5'h00: return s_ob_tar[k];
          5'h04: return s_ob_ext[k];
          5'h08: return s_ob_base[k];
          5'h10: return s_ob_attr[k];
          default: return 32'h0;
        endcase
      end
    for (int j = 0; j < 3; j++)
      if (a[11:5] == 7'((12'hDA0 + 12'(32 * j)) >> 5)) begin
        case (s)
          5'h00: return s_ib_tar[j];
          5'h08: return s_ib_base[j];
          5'h0C: return s_ib_extb[j];
          5'h10: return s_ib_attr[j];
          default: return 32'h0;
        endcase
      end
    return 32'h0;
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    logic [4:0] s;
    s = a[4:0];
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
    @(negedge clk);
    reg_wen = 1'b0;
    if (a == 12'hE20) s_tmr = d;
    for (int k = 1; k <= 4; k++)
      if (a[11:5] == 7'((12'hC00 + 12'(32 * k)) >> 5))
        case (s)
          5'h00: s_ob_tar[k] = d;
          5'h04: s_ob_ext[k] = d;
          5'h08: s_ob_base[k] = d;
          5'h10: s_ob_attr[k] = d;
          default: ;
        endcase
    for (int j = 0; j < 3; j++)
      if (a[11:5] == 7'((12'hDA0 + 12'(32 * j)) >> 5))
        case (s)
          5'h00: s_ib_tar[j] = d;
          5'h08: s_ib_base[j] = d;
          5'h0C: s_ib_extb[j] = d;
          5'h10: s_ib_attr[j] = d;
          default: ;
        endcase
  endtask

  task automatic rd_check(input logic [11:0] a, input string req);
    logic [31:0] e;
    @(negedge clk);
    reg_addr = a;
    #1;
    e = model_read(a);
    check(reg_rdata === e, req, 64'(reg_rdata), 64'(e));
  endtask

  task automatic ob_look(input logic [63:0] a, input string req);
    logic h; logic [63:0] x, xt; logic [2:0] w;
    h = 1'b0; x = '0; w = '0;
    for (int k = 4; k >= 1; k--)
      if (win_hits(s_ob_tar[k], s_ob_base[k], s_ob_attr[k], a, xt)) begin
        h = 1'b1; x = xt; w = 3'(k);
      end
    @(negedge clk);
    ob_req_valid = 1'b1; ob_req_addr = a; ob_rsp_ready = 1'b1;
    @(negedge clk);
    ob_req_valid = 1'b0;
    check(ob_rsp_valid && ob_rsp_hit == h && ob_rsp_miss == !h && ob_rsp_addr === x && ob_rsp_win == w,
          req, {ob_rsp_addr[59:0], 1'b0, ob_rsp_win}, {x[59:0], 1'b0, w});
  endtask

  task automatic ib_look(input logic [63:0] a, input string req);
    logic h; logic [63:0] x, xt; logic [1:0] w;
    h = 1'b0; x = '0; w = '0;
    for (int j = 2; j >= 0; j--)
      if (win_hits(s_ib_tar[j], s_ib_base[j], s_ib_attr[j], a, xt)) begin
        h = 1'b1; x = xt; w = 2'(j);
      end
    @(negedge clk);
    ib_req_valid = 1'b1; ib_req_addr = a; ib_rsp_ready = 1'b1;
    @(negedge clk);
    ib_req_valid = 1'b0;
    check(ib_rsp_valid && ib_rsp_hit == h && ib_rsp_miss == !h && ib_rsp_addr === x && ib_rsp_win == w,
          req, {ib_rsp_addr[59:0], 2'b0, ib_rsp_win}, {x[59:0], 2'b0, w});
  endtask

  function automatic logic [11:0] ob_off(input int k, input logic [4:0] s);
    return 12'hC00 + 12'(32 * k) + 12'(s);
  endfunction
  function automatic logic [11:0] ib_off(input int j, input logic [4:0] s);
    return 12'hDA0 + 12'(32 * j) + 12'(s);
  endfunction

  initial begin : watchdog
    int cyc;
    cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin : main
    void'($urandom(32'd24681));
    for (int k = 1; k <= 4; k++) begin s_ob_tar[k] = 0; s_ob_ext[k] = 0; s_ob_base[k] = 0; s_ob_attr[k] = 0; end
    for (int j = 0; j < 3; j++) begin s_ib_tar[j] = 0; s_ib_base[j] = 0; s_ib_extb[j] = 0; s_ib_attr[j] = 0; end
    s_tmr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    check(!ob_rsp_valid && !ib_rsp_valid && ob_req_ready && ib_req_ready, "R1",
          {60'h0, ob_rsp_valid, ib_rsp_valid, ob_req_ready, ib_req_ready}, 64'h3);
    rd_check(ob_off(1, 5'h10), "R1");
    rd_check(ib_off(2, 5'h08), "R1");
    rd_check(12'hE20, "R1");
    ob_look(64'h0, "R1");
    ib_look(64'h0, "R1");

    // R2: every field of one outbound and one inbound window
    wr(ob_off(2, 5'h00), 32'hA1A1_0001);
    wr(ob_off(2, 5'h04), 32'hA1A1_0002);
    wr(ob_off(2, 5'h08), 32'hA1A1_0003);
    wr(ob_off(2, 5'h10), 32'h7FFF_FFC5);
    wr(ib_off(0, 5'h00), 32'hB2B2_0001);
    wr(ib_off(0, 5'h08), 32'hB2B2_0002);
    wr(ib_off(0, 5'h0C), 32'hB2B2_0003);
    wr(ib_off(0, 5'h10), 32'h0005_5000);
    rd_check(ob_off(2, 5'h00), "R2");
    rd_check(ob_off(2, 5'h04), "R2");
    rd_check(ob_off(2, 5'h08), "R2");
    rd_check(ob_off(2, 5'h10), "R2");
    rd_check(12'hDA0, "R2");
    rd_check(12'hDA8, "R2");
    rd_check(12'hDAC, "R2");
    rd_check(12'hDB0, "R2");

    // R12: timer register
    wr(12'hE20, 32'hDEAD_BEEF);
    rd_check(12'hE20, "R12");
    ob_look(64'h0, "R12");

    // R3: undecoded offsets
    wr(12'h100, 32'hFFFF_FFFF);
    wr(ob_off(1, 5'h0C), 32'hFFFF_FFFF);
    wr(ib_off(1, 5'h04), 32'hFFFF_FFFF);
    wr(12'hCA0, 32'hFFFF_FFFF);
    rd_check(12'h100, "R3");
    rd_check(ob_off(1, 5'h0C), "R3");
    rd_check(ib_off(1, 5'h04), "R3");
    rd_check(12'hCA0, "R3");
    rd_check(ob_off(1, 5'h08), "R3");
    ob_look(64'h0, "R3");

    // R4/R6/R7: 4 KiB window at page 0x100 translating to page 0x80000
    wr(ob_off(1, 5'h00), 32'h0008_0000);
    wr(ob_off(1, 5'h08), 32'h0000_0100);
    wr(ob_off(1, 5'h10), 32'h8000_000B);
    ob_look(64'h10_0000, "R6");
    ob_look(64'h10_0FFF, "R6");
    ob_look(64'h10_1000, "R6");
    ob_look(64'h0F_FFFF, "R6");
    ob_look(64'h10_0123, "R7");
    wr(ob_off(1, 5'h10), 32'h0000_000B);
    ob_look(64'h10_0123, "R4");

    // R5: clamp of the largest size field
    wr(ob_off(4, 5'h08), 32'h0);
    wr(ob_off(4, 5'h00), 32'h0000_0001);
    wr(ob_off(4, 5'h10), 32'h8000_003F);
    ob_look(64'h7FFF_FFFF_FFFF_FFFF, "R5");
    ob_look(64'h8000_0000_0000_0000, "R5");
    wr(ob_off(4, 5'h10), 32'h8000_0011);
    ob_look(64'h3_FFFF, "R5");
    ob_look(64'h4_0000, "R5");

    // R8: overlapping windows, lowest index wins
    wr(ob_off(3, 5'h08), 32'h0000_0000);
    wr(ob_off(3, 5'h10), 32'h8000_0013);
    wr(ob_off(3, 5'h00), 32'h0000_0500);
    ob_look(64'h1_2345, "R8");
    wr(ib_off(2, 5'h08), 32'h0000_0020);
    wr(ib_off(2, 5'h00), 32'h0000_0777);
    wr(ib_off(2, 5'h10), 32'h8000_000F);
    ib_look(64'h2_0010, "R8");
    wr(ib_off(0, 5'h08), 32'h0000_0020);
    wr(ib_off(0, 5'h10), 32'h8000_000B);
    ib_look(64'h2_0010, "R8");
    ib_look(64'h2_1010, "R8");

    // R9: miss zeroes everything
    ib_look(64'hFFFF_0000_0000_0000, "R9");
    ob_look(64'hFFFF_0000_0000_0000, "R9");

    // R11: lookup accepted on the same edge as the enabling write
    @(negedge clk);
    reg_addr = ob_off(1, 5'h10); reg_wdata = 32'h8000_000B; reg_wen = 1'b1;
    ob_req_valid = 1'b1; ob_req_addr = 64'h10_0040; ob_rsp_ready = 1'b1;
    @(negedge clk);
    reg_wen = 1'b0; ob_req_valid = 1'b0;
    s_ob_attr[1] = 32'h8000_000B;
    check(ob_rsp_valid && ob_rsp_miss, "R11", {62'h0, ob_rsp_valid, ob_rsp_miss}, 64'h3);
    ob_look(64'h10_0040, "R11");

    // R10: stalled response holds, ready follows back-pressure
    @(negedge clk);
    ob_rsp_ready = 1'b0; ob_req_valid = 1'b1; ob_req_addr = 64'h10_0080;
    @(negedge clk);
    ob_req_addr = 64'hFFFF_0000_0000_0000;
    check(ob_rsp_valid && !ob_req_ready && ob_rsp_hit && ob_rsp_addr == 64'h8000_0080 && ob_rsp_win == 3'd1,
          "R10", ob_rsp_addr, 64'h8000_0080);
    repeat (2) @(negedge clk);
    check(ob_rsp_valid && !ob_req_ready && ob_rsp_addr == 64'h8000_0080, "R10", ob_rsp_addr, 64'h8000_0080);
    ob_rsp_ready = 1'b1;
    @(negedge clk);
    ob_req_valid = 1'b0;
    check(ob_rsp_valid && ob_rsp_miss && ob_rsp_addr == 64'h0, "R10", ob_rsp_addr, 64'h0);
    @(negedge clk);
    check(!ob_rsp_valid && ob_req_ready, "R10", {62'h0, ob_rsp_valid, ob_req_ready}, 64'h1);

    // random mix of window programming and lookups
    for (int it = 0; it < 600; it++) begin
      int k, j, f;
      logic [63:0] a;
      if ($urandom % 3 == 0) begin
        f = $urandom % 3;
        if ($urandom % 2) begin
          k = 1 + $urandom % 4;
          case (f)
            0: wr(ob_off(k, 5'h00), $urandom);
            1: wr(ob_off(k, 5'h08), $urandom % 256);
            default: wr(ob_off(k, 5'h10), ($urandom & 32'h8FFF_FFC0) | (12 + $urandom % 8));
          endcase
        end else begin
          j = $urandom % 3;
          case (f)
            0: wr(ib_off(j, 5'h00), $urandom);
            1: wr(ib_off(j, 5'h08), $urandom % 256);
            default: wr(ib_off(j, 5'h10), ($urandom & 32'h8FFF_FFC0) | (12 + $urandom % 8));
          endcase
        end
      end
      k = 1 + $urandom % 4;
      a = ({32'h0, s_ob_base[k]} << 12) + 64'($urandom % 32'h10_0000);
      ob_look(a, "R6 R7 R8 random");
      j = $urandom % 3;
      a = ({32'h0, s_ib_base[j]} << 12) + 64'($urandom % 32'h10_0000);
      ib_look(a, "R6 R7 R8 random");
      if (it % 50 == 0) rd_check(ob_off(k, 5'h10), "R2 random");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule